// File: doc/BRIEF.md
# Iterative Bit Scan Unit

This block returns the position of the first set bit in a 16-bit or 32-bit operand. A direction input picks the scan order. A forward scan starts at bit 0 and moves up. A reverse scan starts at the top bit of the selected size and moves down. The unit tests one bit position per step, so a scan that skips many clear bits takes longer than one that finds a set bit early.

A request is a single-cycle `start` pulse carrying the operand, the direction and the size. The operand is captured at that edge, so the inputs may change afterwards.

When the scan finishes, the unit raises `done` for one cycle and reports the zero flag. For a nonzero operand it also raises `dst_we` and presents the found index on `dst_idx`. An all-zero operand is detected when the request is captured. That case finishes after the base time only, with the flag set and no destination write.

Top module: `bscan_unit`

## Requirements
- R1: A request whose effective operand is zero ends exactly 10 cycles after the accepting edge with `done`=1, `zf`=1 and `dst_we`=0, and `dst_idx` keeps its previous value.
- R2: A request whose effective operand is nonzero ends with `done`=1, `zf`=0, `dst_we`=1, and `dst_idx` equal to the position of the first set bit found.
- R3: When `dir_rev`=0 the scan starts at bit 0 and moves upward, so the reported position is that of the lowest set bit.
- R4: When `dir_rev`=1 the scan starts at bit 15 (`size16`=1) or bit 31 (`size16`=0) and moves downward, so the reported position is that of the highest set bit within the selected size.
- R5: `done` rises 10+3n cycles after the accepting edge, where n is the number of clear bits skipped before the set bit. That accepting edge counts as cycle 1. n is the index for a forward scan, and the top bit position minus the index for a reverse scan. `done` is high for exactly one cycle.
- R6: `zf` changes only in a cycle where `done` is high. `dst_idx` changes only in a cycle where `dst_we` is high. `dst_we` is never high without `done`.
- R7: With `size16`=1, operand bits 31:16 are ignored. An operand with only those bits set is treated as zero, and the reported index is zero-extended to 32 bits.
- R8: A `start` pulse that arrives while a scan is in progress is ignored, and the running scan completes with its own result and timing. A `start` in the cycle where `done` is high is accepted.
- R9: After a synchronous active-low reset, `done`, `zf`, `dst_we` and `dst_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse, taken when the unit is idle |
| dir_rev | input | 1 | 0 = scan upward from bit 0, 1 = scan downward from the top bit |
| size16 | input | 1 | 1 = 16-bit operand, 0 = 32-bit operand |
| operand | input | 32 | Value to scan, captured with the request |
| done | output | 1 | One-cycle completion pulse |
| zf | output | 1 | Zero flag, 1 when the effective operand was zero |
| dst_we | output | 1 | Destination write enable, raised with `done` for a nonzero operand |
| dst_idx | output | 32 | Found bit position, zero-extended; held between writes |

## Verification
On every cycle, the checker confirms the following properties:
- `done` is a single-cycle pulse.
- A destination write never happens together with a set zero flag.
- The flag and the index move only at completion.
- The measured latency since the accepted request equals the base time plus three cycles per skipped bit, and the skipped-bit count matches the reported index for the direction and size that were captured.

The bench's scenarios show the following cases:
- Which set bit wins for each direction.
- That the upper half is ignored in 16-bit mode.
- That an index is preserved across a zero operand.
- That an intruding `start` during a scan has no effect.

These are compared against a behavioural model on every clock.

// File: rtl/bscan_pkg.sv
// Package: shared types for the iterative bit scan unit.
// Assumes nothing beyond the users importing it.
package bscan_pkg;

    // Sequencer phases: idle, base-time wait, per-bit stepping.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BASE = 2'd1,
        ST_SCAN = 2'd2
    } scan_state_t;

endpackage

// File: rtl/bscan_ctrl.sv
// Module: bscan_ctrl
// Sequencer for the bit scan. It counts the base time after a request,
// then spends STEP_CYC cycles per bit position that is tested and found clear.
// Assumes: BASE_CYC >= 2, STEP_CYC >= 1, and bit_hit/is_zero come from
// registered datapath state.
module bscan_ctrl
    import bscan_pkg::*;
#(
    parameter int BASE_CYC = 10,
    parameter int STEP_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_zero,
    input  logic bit_hit,
    output logic load,
    output logic step,
    output logic finish,
    output logic done,
    output logic zf,
    output logic dst_we
);

    localparam int BASE_LOAD = BASE_CYC - 2;
    localparam int STEP_LOAD = STEP_CYC - 1;
    localparam int CNT_TOP   = (BASE_LOAD > STEP_LOAD) ? BASE_LOAD : STEP_LOAD;
    localparam int CW        = $clog2(CNT_TOP + 2);
    localparam logic [CW-1:0] BASE_INIT = CW'(BASE_LOAD);
    localparam logic [CW-1:0] STEP_INIT = CW'(STEP_LOAD);

    scan_state_t   state;
    logic [CW-1:0] cnt;
    logic          tick;

    // Decode the events of the current cycle from the state and the counter.
    always_comb begin
        load   = (state == ST_IDLE) && start;
        tick   = (state != ST_IDLE) && (cnt == '0);
        finish = tick && (is_zero || bit_hit);
        step   = tick && !finish;
    end

    // Advance the phase and the wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (load) begin
            state <= ST_BASE;
            cnt   <= BASE_INIT;
        end else if (finish) begin
            state <= ST_IDLE;
        end else if (step) begin
            state <= ST_SCAN;
            cnt   <= STEP_INIT;
        end else if (state != ST_IDLE) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Register the completion pulse, the write enable and the zero flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            zf     <= 1'b0;
            dst_we <= 1'b0;
        end else begin
            done   <= finish;
            dst_we <= finish && !is_zero;
            if (finish) zf <= is_zero;
        end
    end

endmodule

// File: rtl/bscan_path.sv
// Module: bscan_path
// Datapath for the bit scan. It captures the size-masked operand, the
// direction and the zero status, walks the bit index and holds the result.
// Assumes: W is a power of two and step is never raised on a zero operand.
module bscan_path #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         commit,
    input  logic         dir_rev,
    input  logic         size16,
    input  logic [W-1:0] operand,
    output logic         is_zero,
    output logic         bit_hit,
    output logic [W-1:0] dst_idx
);

    localparam int HALF = W / 2;
    localparam int IW   = $clog2(W);
    localparam logic [W-1:0]  HALF_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};
    localparam logic [IW-1:0] TOP_FULL  = IW'(W - 1);
    localparam logic [IW-1:0] TOP_HALF  = IW'(HALF - 1);

    logic [W-1:0]  masked;
    logic [IW-1:0] first_idx;
    logic [W-1:0]  opnd;
    logic [IW-1:0] idx;
    logic          rev;

    // Apply the operand size and choose where the walk begins.
    always_comb begin
        masked    = size16 ? (operand & HALF_MASK) : operand;
        first_idx = dir_rev ? (size16 ? TOP_HALF : TOP_FULL) : '0;
        bit_hit   = opnd[idx];
    end

    // Capture a request and walk the index one position per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd    <= '0;
            idx     <= '0;
            rev     <= 1'b0;
            is_zero <= 1'b0;
        end else if (load) begin
            opnd    <= masked;
            idx     <= first_idx;
            rev     <= dir_rev;
            is_zero <= (masked == '0);
        end else if (step) begin
            idx <= rev ? (idx - 1'b1) : (idx + 1'b1);
        end
    end

    // Hold the result; write it only for a nonzero operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_idx <= '0;
        end else if (commit && !is_zero) begin
            dst_idx <= {{(W - IW){1'b0}}, idx};
        end
    end

endmodule

// File: rtl/bscan_unit.sv
// Module: bscan_unit
// Top of the iterative bit scan unit: sequencer plus datapath.
// Assumes a single-cycle start pulse; starts seen while busy are dropped.
module bscan_unit #(
    parameter int W        = 32,
    parameter int BASE_CYC = 10,
    parameter int STEP_CYC = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         dir_rev,
    input  logic         size16,
    input  logic [W-1:0] operand,
    output logic         done,
    output logic         zf,
    output logic         dst_we,
    output logic [W-1:0] dst_idx
);

    logic load;
    logic step;
    logic finish;
    logic is_zero;
    logic bit_hit;

    bscan_ctrl #(
        .BASE_CYC (BASE_CYC),
        .STEP_CYC (STEP_CYC)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .is_zero (is_zero),
        .bit_hit (bit_hit),
        .load    (load),
        .step    (step),
        .finish  (finish),
        .done    (done),
        .zf      (zf),
        .dst_we  (dst_we)
    );

    bscan_path #(
        .W (W)
    ) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .commit  (finish),
        .dir_rev (dir_rev),
        .size16  (size16),
        .operand (operand),
        .is_zero (is_zero),
        .bit_hit (bit_hit),
        .dst_idx (dst_idx)
    );

endmodule

// File: rtl/bscan_chk.sv
// Module: bscan_chk
// Assertion checker bound to bscan_unit. It keeps its own request tracker
// and latency counter, built from the ports only.
// Assumes the same parameters as the unit it is bound to.
module bscan_chk #(
    parameter int W        = 32,
    parameter int BASE_CYC = 10,
    parameter int STEP_CYC = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         dir_rev,
    input logic         size16,
    input logic         done,
    input logic         zf,
    input logic         dst_we,
    input logic [W-1:0] dst_idx
);

    logic        busy;
    logic [15:0] lat;
    logic        cap_rev;
    logic        cap_16;
    int          lat_i;
    int          skip_i;
    logic        lat_ok;
    logic        skip_ok;

    // Track the accepted request and count the cycles since it was taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            lat     <= '0;
            cap_rev <= 1'b0;
            cap_16  <= 1'b0;
        end else if (start && (!busy || done)) begin
            busy    <= 1'b1;
            lat     <= 16'd1;
            cap_rev <= dir_rev;
            cap_16  <= size16;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            lat <= lat + 16'd1;
        end
    end

    // Derive the expected latency relations from the reported index.
    always_comb begin
        lat_i   = int'(lat);
        skip_i  = cap_rev ? (((cap_16 ? (W / 2) : W) - 1) - int'(dst_idx)) : int'(dst_idx);
        lat_ok  = (lat_i >= BASE_CYC) && (((lat_i - BASE_CYC) % STEP_CYC) == 0);
        skip_ok = (lat_i == BASE_CYC + STEP_CYC * skip_i);
    end

    AST_DONE_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                 // R5
    AST_LATENCY_GRID:    assert property (@(posedge clk) disable iff (!rst_n) done |-> (busy && lat_ok));      // R5
    AST_ZERO_BASE_ONLY:  assert property (@(posedge clk) disable iff (!rst_n) (done && zf) |-> (lat_i == BASE_CYC)); // R1
    AST_ZERO_NO_WRITE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (zf != dst_we));        // R1
    AST_WE_WITH_DONE:    assert property (@(posedge clk) disable iff (!rst_n) dst_we |-> done);                // R6
    AST_ZF_AT_DONE:      assert property (@(posedge clk) disable iff (!rst_n) !$stable(zf) |-> done);          // R6
    AST_IDX_AT_WRITE:    assert property (@(posedge clk) disable iff (!rst_n) !$stable(dst_idx) |-> dst_we);   // R6
    AST_SKIP_MATCH:      assert property (@(posedge clk) disable iff (!rst_n) dst_we |-> skip_ok);             // R3
    AST_HALF_RANGE:      assert property (@(posedge clk) disable iff (!rst_n) (dst_we && cap_16) |-> (int'(dst_idx) < W / 2)); // R7

endmodule

bind bscan_unit bscan_chk #(
    .W        (W),
    .BASE_CYC (BASE_CYC),
    .STEP_CYC (STEP_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .dir_rev (dir_rev),
    .size16  (size16),
    .done    (done),
    .zf      (zf),
    .dst_we  (dst_we),
    .dst_idx (dst_idx)
);

// File: tb/bscan_unit_tb.sv
`timescale 1ns/1ps
// Bench for bscan_unit: directed scenarios plus a behavioural model
// compared on every clock.
module bscan_unit_tb;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         dir_rev = 1'b0;
    logic         size16 = 1'b0;
    logic [W-1:0] operand = '0;
    logic         done;
    logic         zf;
    logic         dst_we;
    logic [W-1:0] dst_idx;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    bscan_unit #(.W(W), .BASE_CYC(10), .STEP_CYC(3)) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .dir_rev (dir_rev),
        .size16 (size16), .operand (operand), .done (done), .zf (zf),
        .dst_we (dst_we), .dst_idx (dst_idx)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int   m_rem = 0;
    bit   m_busy = 0, m_done = 0, m_we = 0, m_zf = 0, p_zero = 0;
    int   m_idx = 0, p_idx = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_we = 0; m_zf = 0; m_idx = 0; m_rem = 0;
        end else begin
            m_done = 0;
            m_we   = 0;
            if (m_busy) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_done = 1;
                    m_busy = 0;
                    m_zf   = p_zero;
                    if (!p_zero) begin
                        m_we  = 1;
                        m_idx = p_idx;
                    end
                end
            end else if (start) begin
                int n;
                int skip;
                n = size16 ? 16 : 32;
                p_zero = 1;
                skip = 0;
                if (dir_rev) begin
                    for (int i = n - 1; i >= 0; i--)
                        if (p_zero && operand[i]) begin p_zero = 0; p_idx = i; skip = n - 1 - i; end
                end else begin
                    for (int i = 0; i < n; i++)
                        if (p_zero && operand[i]) begin p_zero = 0; p_idx = i; skip = i; end
                end
                m_busy = 1;
                m_rem  = (p_zero ? 10 : 10 + 3 * skip) - 1;
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(done == m_done, "R5 done timing", done, m_done);
            chk(dst_we == m_we, "R2 dst_we", dst_we, m_we);
            chk(zf == m_zf, "R1 zf", zf, m_zf);
            chk(int'(dst_idx) == m_idx, "R6 dst_idx", dst_idx, m_idx);
        end
    end

    // Issue one request and check its result; optionally inject a start mid-scan.
    task automatic run_op(input logic [W-1:0] op, input bit rev, input bit s16,
                          input bit exp_zero, input int exp_idx, input int exp_lat,
                          input bit intrude, input string tag);
        int lat;
        @(negedge clk);
        operand = op; dir_rev = rev; size16 = s16; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 400) begin
            if (intrude && lat == 5) begin
                operand = 32'h1; dir_rev = ~rev; size16 = 1'b0; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        chk(lat == exp_lat, {tag, " latency R5"}, lat, exp_lat);
        chk(zf == exp_zero, {tag, " zf"}, zf, exp_zero);
        chk(dst_we == !exp_zero, {tag, " dst_we"}, dst_we, !exp_zero);
        chk(int'(dst_idx) == exp_idx, {tag, " dst_idx"}, dst_idx, exp_idx);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(done == 0, "R9 done", done, 0);
        chk(zf == 0, "R9 zf", zf, 0);
        chk(dst_we == 0, "R9 dst_we", dst_we, 0);
        chk(dst_idx == 0, "R9 dst_idx", dst_idx, 0);
        rst_n = 1'b1;

        run_op(32'h0000_0001, 0, 0, 0, 0, 10, 0, "R3 fwd bit0");
        run_op(32'h8000_0000, 0, 0, 0, 31, 103, 0, "R3 fwd bit31");
        run_op(32'h0000_0A00, 0, 0, 0, 9, 37, 0, "R3 fwd lowest");
        run_op(32'h8000_0000, 1, 0, 0, 31, 10, 0, "R4 rev bit31");
        run_op(32'h0000_0000, 0, 0, 1, 31, 10, 0, "R1 zero keeps idx");
        run_op(32'hFFFF_0000, 0, 1, 1, 31, 10, 0, "R7 upper ignored");
        run_op(32'hABCD_0100, 1, 1, 0, 8, 31, 0, "R7 rev16 zero-ext");
        run_op(32'h0000_0001, 1, 0, 0, 0, 103, 0, "R4 rev bit0");
        run_op(32'h0010_0F00, 1, 0, 0, 20, 43, 0, "R4 rev highest");
        run_op(32'h0000_0010, 0, 0, 0, 4, 22, 1, "R8 start ignored");
        run_op(32'h0000_8000, 1, 1, 0, 15, 10, 0, "R4 rev16 top");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule